// File: doc/BRIEF.md
# Converter Serial Register Interface

This block is the device-side serial port of a dual-channel converter. A host drives chip select, serial clock and serial data in a clock-idles-high mode 3 protocol. Each transaction opens with a command byte. That byte names one of eight register addresses, gives the transfer direction, and carries a standby flag and a two-bit channel code. The next transfer is then sized by the addressed register: 8, 16 or 24 bits, most significant bit first.

Conversion results arrive as a 16-bit word with a one-cycle strobe. A data-ready output, active low, tells the host that a fresh word is waiting. A calibration-done pulse lets a pending calibration mode in the setup register fall back to normal operation.

The serial inputs are oversampled in the system clock domain. A run of 32 one bits on the data line resynchronises both the framing and the register contents.

Top module: `sif_top`

## Requirements
- R1: A command byte with bit 7 at 0 is decoded as: bits 6:4 register address, bit 3 direction (1 = read), bit 2 standby, bits 1:0 channel. `standby` and `chan_sel` take the byte's bit 2 and bits 1:0. A byte with bit 7 at 1 is ignored and framing waits for a new command byte.
- R2: The transfer that follows a command is 16 bits for address 3 (data), 24 bits for addresses 6 (offset) and 7 (gain), and 8 bits for every other address. A write command to address 0 has no data phase. Bits move MSB first.
- R3: `sdi` is sampled on rising `sclk` edges and `sdo` changes on falling edges. `sdo_oe` rises at the first falling edge of a read's data phase and drops after the rising edge of its last bit.
- R4: After reset: setup = 0x01, clock = 0x05, test = 0x00, data = 0x0000, offset = 0x800000, gain = 0x400000, `drdy_n` = 1, `standby` = 0, `chan_sel` = 0, `sdo_oe` = 0.
- R5: Bits 7:5 of the clock register always read as 0, whatever is written.
- R6: A write to the data register (address 3) leaves its contents unchanged.
- R7: Chip select going high abandons any partial command or transfer. A partial write changes no register, and the next bits after chip select falls again are taken as a new command byte.
- R8: 32 consecutive rising `sclk` edges with `sdi` high, while chip select is low, restore every register and the framing to their reset state.
- R9: `conv_strobe` loads `conv_word` into the data register and drives `drdy_n` low. A complete read of the data register drives `drdy_n` high. Reading address 0 returns `drdy_n` in bit 7 and the bits 6:0 of the command just given.
- R10: When setup bits 7:6 are non-zero and `cal_done` pulses, those bits clear to 00 and `drdy_n` goes low.
- R11: A read of address 5 returns 0xFF, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block |
| sdo_oe | output | 1 | High while `sdo` should be driven onto the line |
| drdy_n | output | 1 | Data ready, active low |
| conv_word | input | 16 | New conversion result |
| conv_strobe | input | 1 | One-cycle load pulse for `conv_word` |
| cal_done | input | 1 | One-cycle pulse: calibration finished |
| standby | output | 1 | Standby flag from the last command byte |
| chan_sel | output | 2 | Channel code from the last command byte |

## Verification
The assertions assume that `cs_n`, `sclk` and `sdi` are already synchronous to `clk`, and that each `sclk` level lasts at least two system cycles so that every edge is seen exactly once. They also assume that `sdi` is steady across each rising edge, and that `conv_strobe` and `cal_done` are single-cycle pulses. The bench changes every input just after a falling `clk` edge and holds each `sclk` level for four cycles. It changes `sdi` only while `sclk` is low and raises chip select only with `sclk` high, so all stimulus stays inside those assumptions.

// File: rtl/sif_pkg.sv
`timescale 1ns/1ps
// Shared widths, register address codes and transfer-length lookup for the
// converter serial interface. Assumes addresses are three bits wide.
package sif_pkg;
    localparam int BYTE_W = 8;
    localparam int DATA_W = 16;
    localparam int CAL_W  = 24;
    localparam int LEN_W  = $clog2(CAL_W + 1);

    typedef enum logic [2:0] {
        A_COMM  = 3'd0,
        A_SETUP = 3'd1,
        A_CLOCK = 3'd2,
        A_DATA  = 3'd3,
        A_TEST  = 3'd4,
        A_RSVD  = 3'd5,
        A_OFFS  = 3'd6,
        A_GAIN  = 3'd7
    } sif_addr_e;

    // Number of bits moved in the data phase for a given address.
    function automatic logic [LEN_W-1:0] xfer_len(input sif_addr_e a);
        case (a)
            A_DATA:         return LEN_W'(DATA_W);
            A_OFFS, A_GAIN: return LEN_W'(CAL_W);
            default:        return LEN_W'(BYTE_W);
        endcase
    endfunction
endpackage

// File: rtl/sif_edge.sv
`timescale 1ns/1ps
// Serial clock edge detector. Turns sclk into one-cycle rise and fall
// pulses in the clk domain. Assumes sclk is already synchronous to clk
// and that each level lasts at least one clk cycle.
module sif_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic sclk_q;

    // Hold the previous serial clock level; the idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= sclk;
    end

    assign sclk_rise = sclk & ~sclk_q;
    assign sclk_fall = ~sclk & sclk_q;
endmodule

// File: rtl/sif_shift.sv
`timescale 1ns/1ps
// Framing engine. It collects command bytes, sizes and runs the data
// phase, shifts read data out on falling edges, and detects the run of
// ones that resynchronises the port. Assumes edge pulses from sif_edge
// and a read word that the register file presents combinationally.
module sif_shift
    import sif_pkg::*;
#(
    parameter int RESYNC_ONES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sdi,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic [CAL_W-1:0] rd_word,
    output logic [7:0]       cmd_byte,
    output logic             cmd_stb,
    output sif_addr_e        xfer_addr,
    output logic             wr_stb,
    output logic [CAL_W-1:0] wr_data,
    output logic             rd_done,
    output logic             soft_rst,
    output logic             sdo,
    output logic             sdo_oe
);
    localparam int ONES_W = $clog2(RESYNC_ONES + 1);

    logic              in_cmd;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  len;
    logic              is_read;
    logic [CAL_W-2:0]  in_sr;
    logic [CAL_W-1:0]  out_sr;
    logic [ONES_W-1:0] ones_cnt;
    logic              sdo_q;
    logic              oe_q;
    sif_addr_e         addr_q;

    logic             live_rise;
    logic             cmd_end;
    logic             data_end;
    logic             opens_phase;
    sif_addr_e        new_addr;
    logic [LEN_W-1:0] new_len;

    // Decode of the byte that completes on this rising edge.
    assign live_rise   = sclk_rise && !cs_n;
    assign soft_rst    = live_rise && sdi && (ones_cnt == ONES_W'(RESYNC_ONES - 1));
    assign cmd_byte    = {in_sr[6:0], sdi};
    assign new_addr    = sif_addr_e'(cmd_byte[6:4]);
    assign new_len     = xfer_len(new_addr);
    assign cmd_end     = live_rise && in_cmd && (cnt == LEN_W'(7)) && !soft_rst;
    assign cmd_stb     = cmd_end && !cmd_byte[7];
    assign opens_phase = cmd_stb && !(new_addr == A_COMM && !cmd_byte[3]);
    assign data_end    = live_rise && !in_cmd && (cnt == len - LEN_W'(1)) && !soft_rst;
    assign wr_stb      = data_end && !is_read;
    assign rd_done     = data_end && is_read;
    assign wr_data     = {in_sr, sdi};
    assign xfer_addr   = addr_q;
    assign sdo         = sdo_q;
    assign sdo_oe      = oe_q;

    // Framing state: bit counting, phase changes and the shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n || soft_rst) begin
            in_cmd   <= 1'b1;
            cnt      <= '0;
            len      <= LEN_W'(BYTE_W);
            is_read  <= 1'b0;
            in_sr    <= '0;
            out_sr   <= '0;
            ones_cnt <= '0;
            sdo_q    <= 1'b1;
            oe_q     <= 1'b0;
            addr_q   <= A_COMM;
        end else begin
            if (sclk_rise) begin
                ones_cnt <= sdi ? ones_cnt + ONES_W'(1) : '0;
                in_sr    <= {in_sr[CAL_W-3:0], sdi};
                if (cmd_end) begin
                    cnt <= '0;
                    if (opens_phase) begin
                        in_cmd  <= 1'b0;
                        addr_q  <= new_addr;
                        len     <= new_len;
                        is_read <= cmd_byte[3];
                        out_sr  <= rd_word << (CAL_W - int'(new_len));
                    end
                end else if (data_end) begin
                    cnt    <= '0;
                    in_cmd <= 1'b1;
                    oe_q   <= 1'b0;
                end else begin
                    cnt <= cnt + LEN_W'(1);
                end
            end
            if (sclk_fall && !in_cmd && is_read) begin
                sdo_q  <= out_sr[CAL_W-1];
                out_sr <= {out_sr[CAL_W-2:0], 1'b0};
                oe_q   <= 1'b1;
            end
        end
    end

    assert_oe_off_after_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !sdo_oe);
    assert_oe_rises_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(sclk_fall));
    assert_resync_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (in_cmd && !sdo_oe && cnt == '0));
    assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb, wr_stb, rd_done, soft_rst}));
endmodule

// File: rtl/sif_regs.sv
`timescale 1ns/1ps
// Register file: setup, clock, data, test, offset and gain, plus the
// standby and channel fields of the last command and the data-ready flag.
// Assumes single-cycle strobes from sif_shift and from the converter side.
module sif_regs
    import sif_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SETUP_RST = 8'h01,
    parameter logic [BYTE_W-1:0] CLOCK_RST = 8'h05,
    parameter logic [CAL_W-1:0]  OFFS_RST  = 24'h800000,
    parameter logic [CAL_W-1:0]  GAIN_RST  = 24'h400000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [6:0]        cmd_fields,
    input  logic              cmd_stb,
    input  sif_addr_e         xfer_addr,
    input  logic              wr_stb,
    input  logic [CAL_W-1:0]  wr_data,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] conv_word,
    input  logic              conv_strobe,
    input  logic              cal_done,
    output logic [CAL_W-1:0]  rd_word,
    output logic              drdy_n,
    output logic              standby,
    output logic [1:0]        chan_sel
);
    logic [BYTE_W-1:0] setup_q;
    logic [BYTE_W-1:0] clock_q;
    logic [BYTE_W-1:0] test_q;
    logic [DATA_W-1:0] data_q;
    logic [CAL_W-1:0]  offs_q;
    logic [CAL_W-1:0]  gain_q;
    logic              drdy_n_q;
    logic              stby_q;
    logic [1:0]        ch_q;
    logic              cal_pending;

    assign cal_pending = setup_q[7:6] != 2'b00;
    assign drdy_n      = drdy_n_q;
    assign standby     = stby_q;
    assign chan_sel    = ch_q;

    // Read word for the address in the command byte now completing.
    always_comb begin
        case (sif_addr_e'(cmd_fields[6:4]))
            A_COMM:  rd_word = CAL_W'({drdy_n_q, cmd_fields});
            A_SETUP: rd_word = CAL_W'(setup_q);
            A_CLOCK: rd_word = CAL_W'(clock_q);
            A_DATA:  rd_word = CAL_W'(data_q);
            A_TEST:  rd_word = CAL_W'(test_q);
            A_OFFS:  rd_word = offs_q;
            A_GAIN:  rd_word = gain_q;
            default: rd_word = CAL_W'({BYTE_W{1'b1}});
        endcase
    end

    // Register updates; later statements take priority.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            setup_q  <= SETUP_RST;
            clock_q  <= CLOCK_RST;
            test_q   <= '0;
            data_q   <= '0;
            offs_q   <= OFFS_RST;
            gain_q   <= GAIN_RST;
            drdy_n_q <= 1'b1;
            stby_q   <= 1'b0;
            ch_q     <= 2'b00;
        end else begin
            if (cmd_stb) begin
                stby_q <= cmd_fields[2];
                ch_q   <= cmd_fields[1:0];
            end
            if (rd_done && xfer_addr == A_DATA) drdy_n_q <= 1'b1;
            if (cal_done && cal_pending) begin
                setup_q[7:6] <= 2'b00;
                drdy_n_q     <= 1'b0;
            end
            if (conv_strobe) begin
                data_q   <= conv_word;
                drdy_n_q <= 1'b0;
            end
            if (wr_stb) begin
                case (xfer_addr)
                    A_SETUP: setup_q <= wr_data[BYTE_W-1:0];
                    A_CLOCK: clock_q <= {3'b000, wr_data[4:0]};
                    A_TEST:  test_q  <= wr_data[BYTE_W-1:0];
                    A_OFFS:  offs_q  <= wr_data;
                    A_GAIN:  gain_q  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    assert_strobe_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_strobe && !soft_rst) |=> (!drdy_n && data_q == $past(conv_word)));
    assert_read_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && xfer_addr == A_DATA && !conv_strobe && !soft_rst && !(cal_done && cal_pending))
        |=> drdy_n);
    assert_data_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && xfer_addr == A_DATA && !conv_strobe && !soft_rst) |=> $stable(data_q));
    assert_cal_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && cal_pending && !soft_rst && !(wr_stb && xfer_addr == A_SETUP))
        |=> (setup_q[7:6] == 2'b00 && !drdy_n));
    assert_resync_values_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (setup_q == SETUP_RST && clock_q == CLOCK_RST && offs_q == OFFS_RST && drdy_n));
    assert_rsvd_write_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && xfer_addr == A_RSVD && !soft_rst && !conv_strobe && !cal_done)
        |=> ($stable(setup_q) && $stable(clock_q) && $stable(test_q)
             && $stable(offs_q) && $stable(gain_q) && $stable(data_q)));
endmodule

// File: rtl/sif_top.sv
`timescale 1ns/1ps
// Top of the converter serial register interface: edge detector, framing
// engine and register file. Assumes all inputs are synchronous to clk.
module sif_top
    import sif_pkg::*;
#(
    parameter int                RESYNC_ONES = 32,
    parameter logic [CAL_W-1:0]  OFFS_RST    = 24'h800000,
    parameter logic [CAL_W-1:0]  GAIN_RST    = 24'h400000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              drdy_n,
    input  logic [DATA_W-1:0] conv_word,
    input  logic              conv_strobe,
    input  logic              cal_done,
    output logic              standby,
    output logic [1:0]        chan_sel
);
    logic             sclk_rise;
    logic             sclk_fall;
    logic [CAL_W-1:0] rd_word;
    logic [7:0]       cmd_byte;
    logic             cmd_stb;
    sif_addr_e        xfer_addr;
    logic             wr_stb;
    logic [CAL_W-1:0] wr_data;
    logic             rd_done;
    logic             soft_rst;

    sif_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    sif_shift #(.RESYNC_ONES(RESYNC_ONES)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .rd_word   (rd_word),
        .cmd_byte  (cmd_byte),
        .cmd_stb   (cmd_stb),
        .xfer_addr (xfer_addr),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .rd_done   (rd_done),
        .soft_rst  (soft_rst),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    sif_regs #(.OFFS_RST(OFFS_RST), .GAIN_RST(GAIN_RST)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .cmd_fields  (cmd_byte[6:0]),
        .cmd_stb     (cmd_stb),
        .xfer_addr   (xfer_addr),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .rd_done     (rd_done),
        .conv_word   (conv_word),
        .conv_strobe (conv_strobe),
        .cal_done    (cal_done),
        .rd_word     (rd_word),
        .drdy_n      (drdy_n),
        .standby     (standby),
        .chan_sel    (chan_sel)
    );
endmodule

// File: tb/sif_top_bench.sv
`timescale 1ns/1ps
module sif_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n;
    logic        sclk;
    logic        sdi;
    logic        sdo;
    logic        sdo_oe;
    logic        drdy_n;
    logic [15:0] conv_word;
    logic        conv_strobe;
    logic        cal_done;
    logic        standby;
    logic [1:0]  chan_sel;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sif_top u_sif_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .drdy_n(drdy_n), .conv_word(conv_word),
        .conv_strobe(conv_strobe), .cal_done(cal_done), .standby(standby),
        .chan_sel(chan_sel)
    );

    // Write-then-read vectors: address, length, value written, value read back.
    localparam int V_N = 7;
    localparam int V_ADDR[V_N] = '{1, 2, 4, 6, 7, 5, 3};
    localparam int V_LEN [V_N] = '{8, 8, 8, 24, 24, 8, 16};
    localparam int V_WR  [V_N] = '{'h3C, 'hFF, 'hA5, 'h123456, 'hFEDCBA, 'h00, 'hBEEF};
    localparam int V_RD  [V_N] = '{'h3C, 'h1F, 'hA5, 'h123456, 'hFEDCBA, 'hFF, 'h0000};

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bits(input int n, input logic [23:0] din,
                              output logic [23:0] dout, output logic oe_all);
        dout   = '0;
        oe_all = 1'b1;
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0;
            sdi  = din[i];
            wait_clks(4);
            dout   = {dout[22:0], sdo};
            oe_all = oe_all & sdo_oe;
            sclk = 1'b1;
            wait_clks(4);
        end
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        wait_clks(2);
    endtask

    task automatic frame_close();
        cs_n = 1'b1;
        wait_clks(3);
    endtask

    task automatic do_write(input logic [2:0] a, input int n, input logic [23:0] v,
                            input logic [2:0] ctl);
        logic [23:0] junk;
        logic        oe;
        frame_open();
        shift_bits(8, {16'h0, 1'b0, a, 1'b0, ctl}, junk, oe);
        if (n > 0) shift_bits(n, v, junk, oe);
        frame_close();
    endtask

    task automatic do_read(input logic [2:0] a, input int n, input logic [2:0] ctl,
                           output logic [23:0] v, output logic oe_ok);
        logic [23:0] junk;
        logic        oe;
        frame_open();
        shift_bits(8, {16'h0, 1'b0, a, 1'b1, ctl}, junk, oe);
        shift_bits(n, 24'h0, v, oe);
        oe_ok = oe && !sdo_oe;
        frame_close();
    endtask

    initial begin
        logic [23:0] rv;
        logic [23:0] junk;
        logic        ok;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0;
        conv_word = '0; conv_strobe = 1'b0; cal_done = 1'b0;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(2);

        // R4: reset state at the ports and in the registers.
        check("R4 drdy_n", 24'(drdy_n), 24'h1);
        check("R4 sdo_oe", 24'(sdo_oe), 24'h0);
        check("R4 standby/chan", 24'({standby, chan_sel}), 24'h0);
        do_read(3'd1, 8, 3'b000, rv, ok);  check("R4 setup", rv, 24'h01);
        do_read(3'd2, 8, 3'b000, rv, ok);  check("R4 clock", rv, 24'h05);
        do_read(3'd6, 24, 3'b000, rv, ok); check("R4 offset", rv, 24'h800000);
        do_read(3'd7, 24, 3'b000, rv, ok); check("R4 gain", rv, 24'h400000);
        check("R3 output enable window", 24'(ok), 24'h1);

        // R2 R5 R6 R11: vector table of writes and read-backs.
        for (int i = 0; i < V_N; i++) begin
            do_write(3'(V_ADDR[i]), V_LEN[i], 24'(V_WR[i]), 3'b000);
            do_read(3'(V_ADDR[i]), V_LEN[i], 3'b000, rv, ok);
            check($sformatf("R2/R5/R6/R11 vector %0d", i), rv, 24'(V_RD[i]));
            check("R3 output enable window", 24'(ok), 24'h1);
        end

        // R1: command fields, read of address 0, byte with bit 7 set ignored.
        do_read(3'd0, 8, 3'b110, rv, ok);
        check("R1 comm readback", rv, 24'h8E);
        check("R1 standby/chan", 24'({standby, chan_sel}), 24'h6);
        frame_open();
        shift_bits(8, 24'h87, junk, ok);
        wait_clks(2);
        check("R1 ignored byte", 24'({standby, chan_sel}), 24'h6);
        shift_bits(8, 24'h1E, junk, ok);
        shift_bits(8, 24'h0, rv, ok);
        frame_close();
        check("R1 command after ignored byte", rv, 24'h3C);
        do_write(3'd0, 0, 24'h0, 3'b000);
        check("R1 comm write", 24'({standby, chan_sel}), 24'h0);

        // R9: conversion strobe, status in comm read, release after data read.
        conv_word = 16'h1234; conv_strobe = 1'b1;
        wait_clks(1);
        conv_strobe = 1'b0;
        wait_clks(1);
        check("R9 drdy asserted", 24'(drdy_n), 24'h0);
        do_read(3'd0, 8, 3'b000, rv, ok);
        check("R9 comm bit7", rv, 24'h08);
        do_read(3'd3, 16, 3'b000, rv, ok);
        check("R9 data word", rv, 24'h1234);
        check("R9 drdy released", 24'(drdy_n), 24'h1);

        // R10: calibration mode clears on cal_done.
        do_write(3'd1, 8, 24'h40, 3'b000);
        do_read(3'd1, 8, 3'b000, rv, ok);
        check("R10 mode set", rv, 24'h40);
        cal_done = 1'b1;
        wait_clks(1);
        cal_done = 1'b0;
        wait_clks(1);
        check("R10 drdy after cal", 24'(drdy_n), 24'h0);
        do_read(3'd1, 8, 3'b000, rv, ok);
        check("R10 mode cleared", rv, 24'h00);
        do_read(3'd3, 16, 3'b000, rv, ok);

        // R7: aborted data phase and aborted command byte.
        frame_open();
        shift_bits(8, 24'h40, junk, ok);
        shift_bits(4, 24'hF, junk, ok);
        frame_close();
        do_read(3'd4, 8, 3'b000, rv, ok);
        check("R7 partial write dropped", rv, 24'hA5);
        frame_open();
        shift_bits(5, 24'h03, junk, ok);
        frame_close();
        do_read(3'd2, 8, 3'b000, rv, ok);
        check("R7 new command after abort", rv, 24'h1F);

        // R8: 32 ones restore the reset state.
        do_write(3'd0, 0, 24'h0, 3'b101);
        check("R8 precondition standby", 24'({standby, chan_sel}), 24'h5);
        frame_open();
        shift_bits(16, 24'hFFFF, junk, ok);
        shift_bits(16, 24'hFFFF, junk, ok);
        frame_close();
        check("R8 standby/chan cleared", 24'({standby, chan_sel}), 24'h0);
        do_read(3'd1, 8, 3'b000, rv, ok);  check("R8 setup", rv, 24'h01);
        do_read(3'd2, 8, 3'b000, rv, ok);  check("R8 clock", rv, 24'h05);
        do_read(3'd6, 24, 3'b000, rv, ok); check("R8 offset", rv, 24'h800000);
        do_read(3'd4, 8, 3'b000, rv, ok);  check("R8 test", rv, 24'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule